// File: doc/BRIEF.md
# Fast Interrupt Priority Vectoring Unit

This block arbitrates among a set of numbered interrupt request lines. Each line has a two-bit priority level. Level 0 masks the line, and levels 1 to 3 rank it. Each clock the unit picks one winner and presents it on registered outputs: the winning IRQ number, a flag that marks a fast winner, and a 21-bit direct vector. The downstream core then acknowledges the winner with a single-cycle `ack` pulse.

Two fast channels can promote chosen level-2 requests. Each channel holds a match register that names one IRQ number and carries an enable bit. It also holds a low vector register and a high vector register. When an enabled channel names an active level-2 request, that request beats every other level-2 request, and the unit supplies the channel's 21-bit address directly, so no table lookup is needed. Channel 0 beats channel 1. Level-3 requests still beat any fast request.

A word-addressed register port configures the channels and reads back an active-low pending status word. Writes take effect at the clock edge, and read data is combinational. The output stage is a four-state machine:
- IDLE: no winner.
- NORMAL: a table-indexed winner.
- FAST0: a winner matched by fast channel 0.
- FAST1: a winner matched by fast channel 1.

On every clock the machine moves to whichever state the arbitration result names. Any state can reach any other state, including itself, in one edge. For example, IDLE→NORMAL happens when a request appears, FAST0→FAST1 when channel 0's request goes away, and NORMAL→IDLE when all requests go away.

Top module: `fiv_top`

## Requirements
- R1: After reset the unit is in IDLE: `win_valid`, `win_fast`, `win_irq` and `win_vec` are 0. Every vector register reads 0, both match registers read 0 (fast channels disabled), and the pending word reads 16'hFFFF.
- R2: Among normal candidates, a higher level beats a lower level. At equal level, the lower IRQ number wins. A request at level 0 never wins and never shows as pending.
- R3: An active level-3 request beats any fast level-2 request. The winner is then reported with `win_fast`=0.
- R4: A channel whose enable bit is set, and whose IRQ field names an active level-2 request, makes that request win over every other level-2 request, whatever its number. The winner is reported with `win_fast`=1.
- R5: When both channels match active level-2 requests, channel 0's request wins.
- R6: For a fast winner, `win_vec` equals {high[4:0], low[15:0]} of its channel. For a normal winner, `win_vec` is 0.
- R7: Bits 15..5 of each high vector register read 0, and writes to those bits have no effect.
- R8: The pending word (offset 6) is read-only. Bit 0 always reads 1. Bit j (1..15) reads 0 exactly while IRQ j+1 is requested at a nonzero level and not yet acknowledged, and reads 1 otherwise. IRQs 0 and 1 never appear in it.
- R9: `ack` with a valid winner marks that IRQ as serviced from the next edge, so its pending bit reads 1 at once. The IRQ stops competing, and the winner changes one edge later. It stays serviced until its request line drops.
- R10: Winner outputs change exactly one clock edge after the inputs that decide them. A winner is always a line that was requested at a nonzero level on the previous edge.
- R11: The register map uses these word offsets:
  - 0: channel 0 match
  - 1: channel 0 low vector
  - 2: channel 0 high vector
  - 3: channel 1 match
  - 4: channel 1 low vector
  - 5: channel 1 high vector
  - 6: pending word

  Writes to offsets 7 to 15 are ignored, and reads from them return 0.
- R12: A match register holds the IRQ number in bits 4..0 and the enable in bit 7, and reads back with all other bits 0. A disabled channel, or one naming an IRQ number of 17 or more, never produces a fast winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 17 | Request lines, one per IRQ number |
| irq_lvl | input | 34 | Two-bit level per IRQ, IRQ i in bits 2i+1..2i |
| ack | input | 1 | Acknowledge of the current winner |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| win_valid | output | 1 | A winner is present |
| win_fast | output | 1 | Winner came from a fast channel |
| win_irq | output | 5 | Winning IRQ number |
| win_vec | output | 21 | Direct vector of a fast winner, else 0 |

## Verification
The assertions check the following on every cycle:
- A fast winner always sits at level 2.
- Any winner was requested at a nonzero level one edge earlier.
- An empty request set yields IDLE.
- Normal and idle outputs carry a zero vector.
- High-register reserved bits, pending bit 0 and unmapped reads keep their fixed values.

Other behaviour needs the bench's directed scenarios, because it depends on programmed state and on ordering across cycles. This includes level and number ordering, level 3 beating fast, channel 0 beating channel 1, disabling a channel or pointing it out of range, the exact vector values, and the acknowledge sequence (pending clears at once, the winner moves one edge later, re-arming when the request is dropped).

// File: rtl/fiv_pkg.sv
package fiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_FAST0  = 2'd2,
        ST_FAST1  = 2'd3
    } win_state_e;

    localparam logic [1:0] LVL_OFF  = 2'd0;
    localparam logic [1:0] LVL_FAST = 2'd2;
    localparam logic [1:0] LVL_TOP  = 2'd3;

    localparam int NUM_CH      = 2;
    localparam int REGS_PER_CH = 3;
    localparam int OFS_MATCH   = 0;
    localparam int OFS_LO      = 1;
    localparam int OFS_HI      = 2;
    localparam int OFS_PEND    = NUM_CH * REGS_PER_CH;
    localparam int ENABLE_BIT  = 7;
endpackage

// File: rtl/fiv_regs.sv
module fiv_regs
    import fiv_pkg::*;
#(
    parameter int NUM_IRQ   = 17,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int IRQ_W     = 5,
    parameter int HI_W      = 5,
    parameter int PEND_BASE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_IRQ-1:0]         active,
    output logic [NUM_CH-1:0]          ch_en,
    output logic [NUM_CH*IRQ_W-1:0]    ch_irq,
    output logic [NUM_CH*DATA_W-1:0]   ch_lo,
    output logic [NUM_CH*HI_W-1:0]     ch_hi
);
    logic [DATA_W-1:0] pend_word;

    // one register group per fast channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = c * REGS_PER_CH;
        logic              en_q;
        logic [IRQ_W-1:0]  irq_q;
        logic [DATA_W-1:0] lo_q;
        logic [HI_W-1:0]   hi_q;
        logic sel_m, sel_lo, sel_hi;

        assign sel_m  = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_MATCH));
        assign sel_lo = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_LO));
        assign sel_hi = reg_wr && (reg_addr == ADDR_W'(BASE + OFS_HI));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q  <= 1'b0;
                irq_q <= '0;
                lo_q  <= '0;
                hi_q  <= '0;
            end else begin
                if (sel_m) begin
                    en_q  <= reg_wdata[ENABLE_BIT];
                    irq_q <= reg_wdata[IRQ_W-1:0];
                end
                if (sel_lo) lo_q <= reg_wdata;
                if (sel_hi) hi_q <= reg_wdata[HI_W-1:0];
            end
        end

        assign ch_en[c]                   = en_q;
        assign ch_irq[c*IRQ_W +: IRQ_W]   = irq_q;
        assign ch_lo[c*DATA_W +: DATA_W]  = lo_q;
        assign ch_hi[c*HI_W +: HI_W]      = hi_q;
    end

    // active-low pending word; bit 0 tied high, bit j maps to IRQ j+PEND_BASE-1
    for (genvar j = 0; j < DATA_W; j++) begin : g_pend
        localparam int IDX = j + PEND_BASE - 1;
        if (j == 0) begin : g_fixed
            assign pend_word[j] = 1'b1;
        end else if (IDX < NUM_IRQ) begin : g_live
            assign pend_word[j] = ~active[IDX];
        end else begin : g_none
            assign pend_word[j] = 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(c * REGS_PER_CH + OFS_MATCH)) begin
                reg_rdata[ENABLE_BIT]  = ch_en[c];
                reg_rdata[IRQ_W-1:0]   = ch_irq[c*IRQ_W +: IRQ_W];
            end
            if (reg_addr == ADDR_W'(c * REGS_PER_CH + OFS_LO))
                reg_rdata = ch_lo[c*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(c * REGS_PER_CH + OFS_HI))
                reg_rdata[HI_W-1:0] = ch_hi[c*HI_W +: HI_W];
        end
        if (reg_addr == ADDR_W'(OFS_PEND))
            reg_rdata = pend_word;
    end
endmodule

// File: rtl/fiv_track.sv
module fiv_track
    import fiv_pkg::*;
#(
    parameter int NUM_IRQ = 17,
    parameter int IRQ_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_IRQ-1:0]     irq_req,
    input  logic [2*NUM_IRQ-1:0]   irq_lvl,
    input  logic                   ack,
    input  logic                   win_valid,
    input  logic [IRQ_W-1:0]       win_irq,
    output logic [NUM_IRQ-1:0]     active
);
    logic [NUM_IRQ-1:0] served_q;
    logic [NUM_IRQ-1:0] ack_hit;

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++)
            ack_hit[i] = ack && win_valid && (win_irq == IRQ_W'(i));
    end

    // serviced flag survives only while its request line stays high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) served_q <= '0;
        else        served_q <= irq_req & (served_q | ack_hit);
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_act
        assign active[i] = irq_req[i] && !served_q[i] &&
                           (irq_lvl[2*i +: 2] != LVL_OFF);
    end
endmodule

// File: rtl/fiv_pick.sv
module fiv_pick
    import fiv_pkg::*;
#(
    parameter int NUM_IRQ = 17,
    parameter int IRQ_W   = 5
) (
    input  logic [NUM_IRQ-1:0]       active,
    input  logic [2*NUM_IRQ-1:0]     irq_lvl,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH*IRQ_W-1:0]  ch_irq,
    output win_state_e               nxt_state,
    output logic [IRQ_W-1:0]         nxt_irq
);
    logic [1:0]       best_lvl;
    logic [IRQ_W-1:0] best_irq;
    logic [NUM_CH-1:0] hit;

    // normal ranking: strict compare keeps the lowest number at equal level
    always_comb begin
        best_lvl = LVL_OFF;
        best_irq = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (active[i] && (irq_lvl[2*i +: 2] > best_lvl)) begin
                best_lvl = irq_lvl[2*i +: 2];
                best_irq = IRQ_W'(i);
            end
        end
    end

    // a fast channel hits only on an active level-2 line it names
    always_comb begin
        hit = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (ch_en[c] && (ch_irq[c*IRQ_W +: IRQ_W] == IRQ_W'(i)) &&
                    active[i] && (irq_lvl[2*i +: 2] == LVL_FAST))
                    hit[c] = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_state = ST_IDLE;
        nxt_irq   = '0;
        if (best_lvl == LVL_OFF) begin
            nxt_state = ST_IDLE;
        end else if (best_lvl == LVL_TOP) begin
            nxt_state = ST_NORMAL;
            nxt_irq   = best_irq;
        end else if (hit[0]) begin
            nxt_state = ST_FAST0;
            nxt_irq   = ch_irq[0 +: IRQ_W];
        end else if (hit[1]) begin
            nxt_state = ST_FAST1;
            nxt_irq   = ch_irq[IRQ_W +: IRQ_W];
        end else begin
            nxt_state = ST_NORMAL;
            nxt_irq   = best_irq;
        end
    end
endmodule

// File: rtl/fiv_top.sv
module fiv_top
    import fiv_pkg::*;
#(
    parameter int NUM_IRQ   = 17,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int HI_W      = 5,
    parameter int PEND_BASE = 2,
    localparam int IRQ_W    = $clog2(NUM_IRQ),
    localparam int VEC_W    = DATA_W + HI_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic [2*NUM_IRQ-1:0]  irq_lvl,
    input  logic                  ack,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  win_valid,
    output logic                  win_fast,
    output logic [IRQ_W-1:0]      win_irq,
    output logic [VEC_W-1:0]      win_vec
);
    logic [NUM_IRQ-1:0]       active;
    logic [NUM_CH-1:0]        ch_en;
    logic [NUM_CH*IRQ_W-1:0]  ch_irq;
    logic [NUM_CH*DATA_W-1:0] ch_lo;
    logic [NUM_CH*HI_W-1:0]   ch_hi;
    win_state_e               nxt_state;
    win_state_e               state_q;
    logic [IRQ_W-1:0]         nxt_irq;
    logic [IRQ_W-1:0]         irq_q;
    logic [VEC_W-1:0]         vec_q;

    fiv_regs #(
        .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .IRQ_W(IRQ_W), .HI_W(HI_W), .PEND_BASE(PEND_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active(active),
        .ch_en(ch_en), .ch_irq(ch_irq), .ch_lo(ch_lo), .ch_hi(ch_hi)
    );

    fiv_track #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_track (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .ack(ack), .win_valid(win_valid), .win_irq(win_irq), .active(active)
    );

    fiv_pick #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_pick (
        .active(active), .irq_lvl(irq_lvl), .ch_en(ch_en), .ch_irq(ch_irq),
        .nxt_state(nxt_state), .nxt_irq(nxt_irq)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt_state;
    end

    // registered outputs that accompany the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
            vec_q <= '0;
        end else begin
            unique case (nxt_state)
                ST_IDLE: begin
                    irq_q <= '0;
                    vec_q <= '0;
                end
                ST_NORMAL: begin
                    irq_q <= nxt_irq;
                    vec_q <= '0;
                end
                ST_FAST0: begin
                    irq_q <= nxt_irq;
                    vec_q <= {ch_hi[0 +: HI_W], ch_lo[0 +: DATA_W]};
                end
                ST_FAST1: begin
                    irq_q <= nxt_irq;
                    vec_q <= {ch_hi[HI_W +: HI_W], ch_lo[DATA_W +: DATA_W]};
                end
                default: begin
                    irq_q <= '0;
                    vec_q <= '0;
                end
            endcase
        end
    end

    assign win_valid = (state_q != ST_IDLE);
    assign win_fast  = (state_q == ST_FAST0) || (state_q == ST_FAST1);
    assign win_irq   = irq_q;
    assign win_vec   = vec_q;
endmodule

// File: rtl/fiv_checker.sv
module fiv_checker #(
    parameter int NUM_IRQ = 17,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int IRQ_W   = 5,
    parameter int VEC_W   = 21,
    parameter int HI_W    = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_IRQ-1:0]    irq_req,
    input logic [2*NUM_IRQ-1:0]  irq_lvl,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic                  win_valid,
    input logic                  win_fast,
    input logic [IRQ_W-1:0]      win_irq,
    input logic [VEC_W-1:0]      win_vec
);
    logic [NUM_IRQ-1:0]   req_q;
    logic [2*NUM_IRQ-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            lvl_q <= '0;
        end else begin
            req_q <= irq_req;
            lvl_q <= irq_lvl;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (!win_fast && win_irq == '0 && win_vec == '0));

    p_fast_is_level2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_fast |-> (lvl_q[{win_irq, 1'b0} +: 2] == 2'd2));

    p_normal_vec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_fast) |-> (win_vec == '0));

    p_winner_requested_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (req_q[win_irq] && lvl_q[{win_irq, 1'b0} +: 2] != 2'd0));

    p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0) |-> !win_valid);

    p_high_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(2) || reg_addr == ADDR_W'(5)) |->
            (reg_rdata[DATA_W-1:HI_W] == '0));

    p_pend_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(6)) |-> reg_rdata[0]);

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(6)) |-> (reg_rdata == '0));
endmodule

bind fiv_top fiv_checker #(
    .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IRQ_W(IRQ_W), .VEC_W(VEC_W), .HI_W(HI_W)
) u_fiv_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .win_valid(win_valid),
    .win_fast(win_fast), .win_irq(win_irq), .win_vec(win_vec)
);

// File: tb/tb_fiv_top.sv
module tb_fiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] irq_req = '0;
    logic [33:0] irq_lvl;
    logic        ack = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        win_valid, win_fast;
    logic [4:0]  win_irq;
    logic [20:0] win_vec;
    logic [1:0]  lvl [17];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 17; i++) irq_lvl[2*i +: 2] = lvl[i];
    end

    fiv_top dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .ack(ack), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .win_valid(win_valid), .win_fast(win_fast),
        .win_irq(win_irq), .win_vec(win_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic winner(input string tag, input logic v, input logic f,
                          input logic [4:0] n, input logic [20:0] vec);
        chk({tag, " valid"}, 32'(win_valid), 32'(v));
        chk({tag, " fast"},  32'(win_fast),  32'(f));
        chk({tag, " irq"},   32'(win_irq),   32'(n));
        chk({tag, " vec"},   32'(win_vec),   32'(vec));
    endtask

    task automatic clear_all();
        irq_req = '0;
        for (int i = 0; i < 17; i++) lvl[i] = 2'd0;
        step(); step();
    endtask

    task automatic t_reset();
        logic [15:0] d;
        winner("R1 reset", 1'b0, 1'b0, 5'd0, 21'd0);
        rd(4'd6, d); chk("R1 pending reset", 32'(d), 32'hFFFF);
        rd(4'd1, d); chk("R1 low0 reset", 32'(d), 32'h0);
        rd(4'd5, d); chk("R1 high1 reset", 32'(d), 32'h0);
        rd(4'd0, d); chk("R1 match0 reset", 32'(d), 32'h0);
    endtask

    task automatic t_normal();
        lvl[5] = 2'd1; lvl[9] = 2'd2;
        irq_req[5] = 1'b1; irq_req[9] = 1'b1;
        #1 chk("R10 not before edge", 32'(win_valid), 32'd0);
        step();
        winner("R2 higher level", 1'b1, 1'b0, 5'd9, 21'd0);
        lvl[4] = 2'd2; irq_req[4] = 1'b1;
        step();
        winner("R2 lower number", 1'b1, 1'b0, 5'd4, 21'd0);
        clear_all();
        lvl[3] = 2'd0; irq_req[3] = 1'b1;
        step();
        winner("R2 level0 masked", 1'b0, 1'b0, 5'd0, 21'd0);
        clear_all();
    endtask

    task automatic t_config();
        logic [15:0] d;
        wr(4'd0, 16'h008C);
        wr(4'd1, 16'hBEEF);
        wr(4'd2, 16'hFFFF);
        wr(4'd3, 16'h0087);
        wr(4'd4, 16'h1234);
        wr(4'd5, 16'h0005);
        rd(4'd2, d); chk("R7 high reserved", 32'(d), 32'h001F);
        rd(4'd0, d); chk("R12 match readback", 32'(d), 32'h008C);
        rd(4'd4, d); chk("R11 low1 readback", 32'(d), 32'h1234);
    endtask

    task automatic t_fast();
        lvl[3] = 2'd2; lvl[12] = 2'd2; lvl[7] = 2'd2;
        irq_req[3] = 1'b1; irq_req[12] = 1'b1;
        step();
        winner("R4 fast promote", 1'b1, 1'b1, 5'd12, 21'h1FBEEF);
        irq_req[7] = 1'b1;
        step();
        winner("R5 ch0 over ch1", 1'b1, 1'b1, 5'd12, 21'h1FBEEF);
        irq_req[12] = 1'b0;
        step();
        winner("R6 ch1 vector", 1'b1, 1'b1, 5'd7, 21'h051234);
        lvl[15] = 2'd3; irq_req[15] = 1'b1;
        step();
        winner("R3 level3 first", 1'b1, 1'b0, 5'd15, 21'd0);
        clear_all();
        wr(4'd0, 16'h000C);
        wr(4'd3, 16'h009F);
        lvl[3] = 2'd2; lvl[12] = 2'd2; lvl[7] = 2'd2;
        irq_req[3] = 1'b1; irq_req[12] = 1'b1; irq_req[7] = 1'b1;
        step();
        winner("R12 disabled or out of range", 1'b1, 1'b0, 5'd3, 21'd0);
        clear_all();
    endtask

    task automatic t_pending_ack();
        logic [15:0] d;
        lvl[0] = 2'd1; lvl[1] = 2'd1; irq_req[0] = 1'b1; irq_req[1] = 1'b1;
        step();
        rd(4'd6, d); chk("R8 irq0/1 absent", 32'(d), 32'hFFFF);
        clear_all();
        lvl[6] = 2'd1; lvl[10] = 2'd1;
        irq_req[6] = 1'b1; irq_req[10] = 1'b1;
        step();
        rd(4'd6, d); chk("R8 pending low", 32'(d), 32'hFDDF);
        winner("R9 before ack", 1'b1, 1'b0, 5'd6, 21'd0);
        wr(4'd6, 16'h0000);
        rd(4'd6, d); chk("R8 read-only", 32'(d), 32'hFDDF);
        ack = 1'b1;
        step();
        ack = 1'b0;
        rd(4'd6, d); chk("R9 pending cleared", 32'(d), 32'hFDFF);
        chk("R9 winner held one edge", 32'(win_irq), 32'd6);
        step();
        winner("R9 next winner", 1'b1, 1'b0, 5'd10, 21'd0);
        step();
        chk("R9 stays serviced", 32'(win_irq), 32'd10);
        irq_req[6] = 1'b0;
        step();
        irq_req[6] = 1'b1;
        step();
        winner("R9 rearmed", 1'b1, 1'b0, 5'd6, 21'd0);
        rd(4'd6, d); chk("R9 pending again", 32'(d), 32'hFDDF);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        wr(4'd9, 16'hFFFF);
        rd(4'd9, d); chk("R11 unmapped read", 32'(d), 32'h0);
        rd(4'd1, d); chk("R11 low0 untouched", 32'(d), 32'hBEEF);
        wr(4'd2, 16'hFFE3);
        rd(4'd2, d); chk("R7 reserved ignored", 32'(d), 32'h0003);
    endtask

    initial begin
        for (int i = 0; i < 17; i++) lvl[i] = 2'd0;
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_normal();
        t_config();
        t_fast();
        t_pending_ack();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule